// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog timer that counts down in units of a slow tick, normally a 32.768 kHz clock presented as a one-cycle enable `tick_i` in the bus clock domain. Software programs a timeout length, enables the timer and then has to keep writing a restart code before the count runs out. On expiry the block either drives a reset pulse of programmable polarity or raises a level interrupt. A keyed software command forces the reset pulse at once.

Every control write is guarded. A mode write needs a key in its top byte. A length write needs a key in its low five bits. The restart and software-reset registers react only to one exact 32-bit code each. A write without the right key or code changes nothing.

The controller is a four-state machine. OFF is the idle state. It moves to RUN (load) when the enable bit is seen, and to PULSE (software reset) on the reset code. RUN reloads on a restart. It counts down on each completed unit and leaves on expiry, going to PULSE in reset mode or to IRQ in interrupt mode. RUN also moves to OFF (disable) and to PULSE (software reset). PULSE lasts a fixed number of slow ticks, then reloads into RUN when enabled, or goes to OFF. IRQ stays until software reads status, then reloads into RUN or goes to OFF. The software-reset code moves IRQ to PULSE.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the mode, length and status registers read 0, `wdt_irq_o` is 0 and `wdt_rst_o` is 1, which is the idle level of the default active-low polarity.
- R2: A write to offset 0x00 is taken only when data bits [31:24] are 0x22. Its bits are then stored: bit 0 enable, bit 1 polarity (1 = active-high), bit 2 reset-output enable, bit 3 interrupt select. A read of 0x00 returns those four bits in [3:0]. Any other write to 0x00 leaves the mode unchanged.
- R3: A write to offset 0x04 is taken only when data bits [4:0] are 0x08. The timeout count is then stored from bits [14:5] (10 bits). A read returns the count in [14:5] with all other bits 0.
- R4: While running, writing exactly 0x0000_1971 to offset 0x08 reloads the counter from the programmed length and clears the tick prescaler. Any other value has no effect.
- R5: In reset mode, the reset pulse starts exactly length × PRESCALE slow ticks after a reload. A programmed length of 0 counts as 1.
- R6: The reset pulse lasts PULSE_TICKS slow ticks and is driven at the level selected by mode bit 1. It reaches the pin only when mode bit 2 is set. Afterwards the timer reloads if it is still enabled.
- R7: In interrupt mode, expiry raises `wdt_irq_o` as a level that holds with no pulse on `wdt_rst_o`. A read of the status register clears it.
- R8: Writing exactly 0x0000_1209 to offset 0x14 starts the reset pulse on the next cycle from any state other than PULSE, even while disabled. Any other value has no effect.
- R9: Status at offset 0x0C has bit 0 for a timeout and bit 1 for a software reset. A read returns the value and clears it, and an event in the same cycle wins over the clear.
- R10: A read of offset 0x10 returns the remaining count. A reload sets it to the effective length.
- R11: Clearing the enable bit stops the countdown, and no expiry follows.
- R12: The prescaler and the counter advance only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per slow-clock tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| wdt_rst_o | output | 1 | Reset pulse at the selected polarity |
| wdt_irq_o | output | 1 | Level interrupt on expiry in interrupt mode |

## Verification
The hardest situation to reach is a mid-count state, where a wrongly coded restart has to be shown to change nothing. The bench lets a 10-count timeout run for a known number of cycles and then writes the wrong code. It reads the remaining count through the interval register and expects the decremented value, not the reloaded one. Tick gating is reached by holding `tick_i` low across a whole timeout window. The bench then releases it and expects expiry after exactly one unit, because the reload cleared the prescaler.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    localparam logic [7:0]        MODE_KEY     = 8'h22;
    localparam logic [4:0]        LEN_KEY      = 5'h08;
    localparam logic [DATA_W-1:0] RESTART_CODE = 32'h0000_1971;
    localparam logic [DATA_W-1:0] SWRST_CODE   = 32'h0000_1209;

    localparam logic [ADDR_W-1:0] OFS_MODE     = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LEN      = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RESTART  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_INTERVAL = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SWRST    = 5'h14;

    localparam int unsigned LEN_LSB = 5;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_PULSE = 2'd2,
        WD_IRQ   = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic irq_sel;
        logic ext_en;
        logic pol_hi;
        logic en;
    } wd_mode_t;

endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
    parameter int unsigned PRESCALE = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic unit_o
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] acc_q;

    assign unit_o = tick_i && !clr_i && (acc_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr_i)  acc_q <= '0;
        else if (tick_i) acc_q <= (acc_q == LAST) ? '0 : acc_q + 1'b1;
    end

    // R12: no slow tick, no prescaler progress
    a_r12_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> (acc_q == $past(acc_q)));

    // R5: prescaler never leaves its range
    a_r5_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= LAST);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_key_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output wd_mode_t          mode_o,
    output logic [CNT_W-1:0]  len_o,
    output logic              restart_o,
    output logic              swrst_o,
    output logic              stat_rd_o,
    input  logic              ev_timeout_i,
    input  logic              ev_swrst_i,
    input  logic [CNT_W-1:0]  cnt_i
);
    wd_mode_t         mode_q;
    logic [CNT_W-1:0] len_q;
    logic [1:0]       stat_q;
    logic             mode_hit, len_hit;
    logic [DATA_W-1:0] rd_mux;

    assign mode_hit  = wr_i && (addr_i == OFS_MODE) && (wdata_i[31:24] == MODE_KEY);
    assign len_hit   = wr_i && (addr_i == OFS_LEN)  && (wdata_i[4:0] == LEN_KEY);
    assign restart_o = wr_i && (addr_i == OFS_RESTART) && (wdata_i == RESTART_CODE);
    assign swrst_o   = wr_i && (addr_i == OFS_SWRST)   && (wdata_i == SWRST_CODE);
    assign stat_rd_o = rd_i && (addr_i == OFS_STATUS);

    assign mode_o = mode_q;
    assign len_o  = len_q;

    always_comb begin
        case (addr_i)
            OFS_MODE:     rd_mux = DATA_W'(mode_q);
            OFS_LEN:      rd_mux = DATA_W'(len_q) << LEN_LSB;
            OFS_STATUS:   rd_mux = DATA_W'(stat_q);
            OFS_INTERVAL: rd_mux = DATA_W'(cnt_i);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            len_q   <= '0;
            stat_q  <= '0;
            rdata_o <= '0;
        end else begin
            if (mode_hit) mode_q <= wd_mode_t'(wdata_i[3:0]);
            if (len_hit)  len_q  <= wdata_i[LEN_LSB +: CNT_W];
            stat_q[0] <= ev_timeout_i | (stat_q[0] & ~stat_rd_o);
            stat_q[1] <= ev_swrst_i   | (stat_q[1] & ~stat_rd_o);
            rdata_o   <= rd_i ? rd_mux : '0;
        end
    end

    // R2: unkeyed mode writes leave the mode alone
    a_r2_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MODE && wdata_i[31:24] != MODE_KEY) |=> (mode_q == $past(mode_q)));

    // R3: unkeyed length writes leave the length alone
    a_r3_len_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_LEN && wdata_i[4:0] != LEN_KEY) |=> (len_q == $past(len_q)));

    // R9: a timeout event is always recorded, even against a clearing read
    a_r9_stat_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timeout_i |=> stat_q[0]);

    // R9: a status read with no new event clears both bits
    a_r9_stat_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_o && !ev_timeout_i && !ev_swrst_i) |=> (stat_q == 2'b00));

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_key_pkg::*;
#(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned PULSE_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             unit_i,
    input  wd_mode_t         mode_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             restart_i,
    input  logic             swrst_i,
    input  logic             stat_rd_i,
    output logic             presc_clr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ev_timeout_o,
    output logic             ev_swrst_o,
    output logic             rst_o,
    output logic             irq_o
);
    localparam int unsigned PCW = $clog2(PULSE_TICKS + 1);
    localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSE_TICKS - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, load_val;
    logic [PCW-1:0]   pcnt_q;
    logic             load, pulse_start, pulse_active;

    assign load_val    = (len_i == '0) ? CNT_W'(1) : len_i;
    assign presc_clr_o = load;
    assign cnt_o       = cnt_q;
    assign pulse_start = (state_d == WD_PULSE) && (state_q != WD_PULSE);

    // next-state decision
    always_comb begin
        state_d      = state_q;
        load         = 1'b0;
        ev_timeout_o = 1'b0;
        ev_swrst_o   = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (swrst_i) begin
                    state_d    = WD_PULSE;
                    ev_swrst_o = 1'b1;
                end else if (mode_i.en) begin
                    state_d = WD_RUN;
                    load    = 1'b1;
                end
            end
            WD_RUN: begin
                if (swrst_i) begin
                    state_d    = WD_PULSE;
                    ev_swrst_o = 1'b1;
                end else if (!mode_i.en) begin
                    state_d = WD_OFF;
                end else if (restart_i) begin
                    load = 1'b1;
                end else if (unit_i && cnt_q <= CNT_W'(1)) begin
                    ev_timeout_o = 1'b1;
                    state_d      = mode_i.irq_sel ? WD_IRQ : WD_PULSE;
                end
            end
            WD_PULSE: begin
                if (tick_i && pcnt_q == PULSE_LAST) begin
                    if (mode_i.en) begin
                        state_d = WD_RUN;
                        load    = 1'b1;
                    end else begin
                        state_d = WD_OFF;
                    end
                end
            end
            WD_IRQ: begin
                if (swrst_i) begin
                    state_d    = WD_PULSE;
                    ev_swrst_o = 1'b1;
                end else if (stat_rd_i) begin
                    if (mode_i.en) begin
                        state_d = WD_RUN;
                        load    = 1'b1;
                    end else begin
                        state_d = WD_OFF;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // countdown and pulse length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pcnt_q <= '0;
        end else begin
            if (load)
                cnt_q <= load_val;
            else if (ev_timeout_o)
                cnt_q <= '0;
            else if (state_q == WD_RUN && unit_i)
                cnt_q <= cnt_q - 1'b1;

            if (pulse_start)
                pcnt_q <= '0;
            else if (state_q == WD_PULSE && tick_i)
                pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        pulse_active = (state_q == WD_PULSE) && mode_i.ext_en;
        rst_o        = mode_i.pol_hi ? pulse_active : !pulse_active;
        irq_o        = (state_q == WD_IRQ);
    end

    // R5: while running the counter never sits at zero
    a_r5_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |-> (cnt_q != '0));

    // R12: without a tick or command the count holds
    a_r12_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && !tick_i && !restart_i && !swrst_i) |=> (cnt_q == $past(cnt_q)));

    // R6: the pulse counter stays inside the pulse length
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_PULSE) |-> (pcnt_q < PCW'(PULSE_TICKS)));

    // R8: the software reset code enters the pulse on the next cycle
    a_r8_swrst_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst_i && state_q != WD_PULSE) |=> (state_q == WD_PULSE));

    // R7: the interrupt holds until status is read
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IRQ && !stat_rd_i && !swrst_i) |=> irq_o);

    // R7: a status read releases the interrupt
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IRQ && stat_rd_i && !swrst_i) |=> !irq_o);

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_key_pkg::*;
#(
    parameter int unsigned PRESCALE    = 512,
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned PULSE_TICKS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 wdt_rst_o,
    output logic                 wdt_irq_o
);
    wd_mode_t         mode;
    logic [CNT_W-1:0] len, cnt;
    logic             restart, swrst, stat_rd, ev_to, ev_sw, presc_clr, unit;

    wdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (bus_wr_i),
        .rd_i         (bus_rd_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .rdata_o      (bus_rdata_o),
        .mode_o       (mode),
        .len_o        (len),
        .restart_o    (restart),
        .swrst_o      (swrst),
        .stat_rd_o    (stat_rd),
        .ev_timeout_i (ev_to),
        .ev_swrst_i   (ev_sw),
        .cnt_i        (cnt)
    );

    wdt_tick_div #(.PRESCALE(PRESCALE)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (presc_clr),
        .unit_o (unit)
    );

    wdt_fsm #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .unit_i       (unit),
        .mode_i       (mode),
        .len_i        (len),
        .restart_i    (restart),
        .swrst_i      (swrst),
        .stat_rd_i    (stat_rd),
        .presc_clr_o  (presc_clr),
        .cnt_o        (cnt),
        .ev_timeout_o (ev_to),
        .ev_swrst_o   (ev_sw),
        .rst_o        (wdt_rst_o),
        .irq_o        (wdt_irq_o)
    );

endmodule

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb_top;
    localparam int P  = 16;
    localparam int PT = 4;
    localparam int CW = 10;

    localparam logic [4:0] A_MODE = 5'h00, A_LEN = 5'h04, A_RESTART = 5'h08,
                           A_STATUS = 5'h0C, A_INTERVAL = 5'h10, A_SWRST = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire         wrst, wirq;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;
    logic rd_q = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    wdt_keyed_top #(.PRESCALE(P), .CNT_W(CW), .PULSE_TICKS(PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .wdt_rst_o(wrst), .wdt_irq_o(wirq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    // driver: issue a read and push the expected item for the monitor
    task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd = 1'b0;
    endtask

    // monitor: compare read data one cycle after the strobe
    always @(posedge clk) rd_q <= rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wait_sig(input bit use_irq, input logic lvl, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk); n++;
            @(negedge clk);
            if ((use_irq ? wirq : wrst) === lvl) return;
        end
        n = limit + 1;
    endtask

    task automatic watch_rst(input logic idle, input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wrst !== idle) hits++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        chk("R1 reset pin idle", 32'(wrst), 32'd1);
        chk("R1 irq low", 32'(wirq), 32'd0);
        bus_rd(A_MODE, 32'h0, "R1 mode after reset");
        bus_rd(A_LEN, 32'h0, "R1 length after reset");
        bus_rd(A_STATUS, 32'h0, "R1 status after reset");

        bus_wr(A_LEN, (32'd5 << 5) | 32'h07);
        bus_rd(A_LEN, 32'h0, "R3 bad length key ignored");
        bus_wr(A_LEN, (32'd5 << 5) | 32'h08);
        bus_rd(A_LEN, 32'd5 << 5, "R3 keyed length stored");

        bus_wr(A_MODE, 32'h2100_000F);
        bus_rd(A_MODE, 32'h0, "R2 bad mode key ignored");
        bus_wr(A_MODE, 32'h2200_0006);
        bus_rd(A_MODE, 32'h6, "R2 keyed mode stored");
        chk("R6 idle level active-high", 32'(wrst), 32'd0);

        // R5 expiry timing and R6 pulse width
        bus_wr(A_LEN, (32'd3 << 5) | 32'h08);
        bus_wr(A_MODE, 32'h2200_0007);
        bus_wr(A_RESTART, 32'h0000_1971);
        wait_sig(1'b0, 1'b1, 400, n);
        chk("R5 expiry after 3 counts", n, 3 * P);
        wait_sig(1'b0, 1'b0, 40, n);
        chk("R6 pulse width", n, PT);
        bus_rd(A_STATUS, 32'h1, "R9 timeout bit");
        bus_rd(A_STATUS, 32'h0, "R9 cleared by read");

        // R4 wrong restart code mid-count, R10 interval readback
        bus_wr(A_LEN, (32'd10 << 5) | 32'h08);
        bus_wr(A_RESTART, 32'h0000_1971);
        repeat (40) @(posedge clk);
        bus_wr(A_RESTART, 32'h0000_1972);
        bus_rd(A_INTERVAL, 32'd8, "R4 wrong restart no reload");
        bus_wr(A_RESTART, 32'h0000_1971);
        bus_rd(A_INTERVAL, 32'd10, "R10 interval after reload");

        // R11 disable halts
        bus_wr(A_MODE, 32'h2200_0006);
        watch_rst(1'b0, 400, n);
        chk("R11 no expiry while disabled", n, 0);
        bus_rd(A_STATUS, 32'h0, "R11 no event while disabled");

        // R12 tick gating
        bus_wr(A_LEN, (32'd1 << 5) | 32'h08);
        @(negedge clk) tick = 1'b0;
        bus_wr(A_MODE, 32'h2200_0007);
        bus_wr(A_RESTART, 32'h0000_1971);
        watch_rst(1'b0, 100, n);
        chk("R12 no progress without ticks", n, 0);
        @(negedge clk) tick = 1'b1;
        wait_sig(1'b0, 1'b1, 100, n);
        chk("R12 expiry one unit after ticks resume", n, P);
        wait_sig(1'b0, 1'b0, 40, n);

        // R5 zero length acts as one
        bus_wr(A_LEN, 32'h08);
        bus_wr(A_RESTART, 32'h0000_1971);
        wait_sig(1'b0, 1'b1, 100, n);
        chk("R5 length zero is one count", n, P);
        wait_sig(1'b0, 1'b0, 40, n);

        // R7 interrupt mode
        bus_wr(A_LEN, (32'd2 << 5) | 32'h08);
        bus_wr(A_MODE, 32'h2200_000F);
        bus_wr(A_RESTART, 32'h0000_1971);
        wait_sig(1'b1, 1'b1, 200, n);
        chk("R7 irq after 2 counts", n, 2 * P);
        chk("R7 no reset pulse in irq mode", 32'(wrst), 32'd0);
        repeat (50) @(negedge clk);
        chk("R7 irq level holds", 32'(wirq), 32'd1);
        bus_rd(A_STATUS, 32'h1, "R7 status shows timeout");
        chk("R7 irq cleared by status read", 32'(wirq), 32'd0);
        bus_wr(A_MODE, 32'h2200_0006);

        // R8 software reset
        bus_wr(A_SWRST, 32'h0000_1208);
        watch_rst(1'b0, 6, n);
        chk("R8 wrong code no pulse", n, 0);
        bus_rd(A_STATUS, 32'h0, "R8 wrong code no event");
        bus_wr(A_SWRST, 32'h0000_1209);
        chk("R8 immediate pulse while disabled", 32'(wrst), 32'd1);
        wait_sig(1'b0, 1'b0, 40, n);
        chk("R8 pulse width", n, PT);
        bus_rd(A_STATUS, 32'h2, "R9 software reset bit");

        // R6 active-low polarity and output gating
        bus_wr(A_MODE, 32'h2200_0004);
        chk("R6 idle level active-low", 32'(wrst), 32'd1);
        bus_wr(A_SWRST, 32'h0000_1209);
        chk("R6 active-low pulse", 32'(wrst), 32'd0);
        wait_sig(1'b0, 1'b1, 40, n);
        chk("R6 active-low width", n, PT);
        bus_rd(A_STATUS, 32'h2, "R9 status before gating test");
        bus_wr(A_MODE, 32'h2200_0000);
        bus_wr(A_SWRST, 32'h0000_1209);
        watch_rst(1'b1, 8, n);
        chk("R6 output gated when disabled", n, 0);
        bus_rd(A_STATUS, 32'h2, "R8 event logged with output gated");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule